// File: doc/BRIEF.md
# Clock Frequency Guard Watchdog

This block protects a programmable clock generator against a bad over-clock setting. Software arms it with an enable level and an 8-bit count, then services it by rewriting either. Time is measured in units built from a free-running one-cycle `tick` pulse. A select bit picks a long unit of `SLOW_DIV` ticks or a short unit of `FAST_DIV` ticks. If the count runs out, the block does three things:
- it latches an alarm,
- it replaces the live frequency-select code with a stored fallback code,
- it pulls an active-low system reset for a fixed number of ticks.

A second trigger for the same reset comes from a ratio monitor. It watches the registered output-divider select word and reacts to any cycle-to-cycle change, whatever the state of the timer.

The timer is a three-state machine:
- `WD_OFF`: idle. It moves to `WD_RUN` when `wd_en` is high and loads the count.
- `WD_RUN`: counting. It returns to `WD_OFF` when `wd_en` drops, and moves to `WD_ALARM` on expiry.
- `WD_ALARM`: latched. It leaves only on `status_clr`, going to `WD_RUN` if `wd_en` is high and to `WD_OFF` otherwise.

The reset generator is a two-state machine:
- `RP_IDLE`: reset released. Any trigger moves it to `RP_HOLD`.
- `RP_HOLD`: reset asserted. It returns to `RP_IDLE` after `RST_TICKS` ticks, and a new trigger while holding restarts that span.

Top module: `freq_guard_wdt`

## Requirements
- R1: After reset, `alarm` is 0, `sys_rst_n` is 1, `freq_code` equals `hw_code`, and the timer is off.
- R2: With `wd_en`=1, the alarm rises on the tick edge that ends unit number max(`wd_count`,1), counted from the last load. A unit is `FAST_DIV` ticks when `base_sel`=1 and `SLOW_DIV` ticks when `base_sel`=0.
- R3: While `wd_en`=0 no alarm is raised. Dropping `wd_en` mid-count abandons the count, and raising it again starts a full new count.
- R4: A one-cycle `cfg_wr` pulse while counting reloads the full count and restarts the current unit.
- R5: In alarm, `freq_code` carries the `safe_code` value sampled at the expiry edge. It stays stable even if `safe_code` changes later.
- R6: `alarm` stays 1 until a `status_clr` pulse, and `cfg_wr` and `wd_en` have no effect on it. After the clear, `freq_code` returns to `hw_code`, and if `wd_en`=1 a full new count starts.
- R7: Expiry drives `sys_rst_n` low from the expiry edge until the edge of the `RST_TICKS`-th following tick, where it returns high.
- R8: A change of `ratio_sel` drives `sys_rst_n` low from the next clock edge for `RST_TICKS` ticks. This happens whether or not the timer is enabled, and leaves `alarm` and `freq_code` unchanged.
- R9: Outside alarm, `freq_code` follows `hw_code` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse |
| wd_en | input | 1 | Watchdog enable level |
| base_sel | input | 1 | 1 selects the short unit, 0 selects the long unit |
| wd_count | input | CNT_W | Timeout in units |
| safe_code | input | CODE_W | Fallback frequency-select code |
| cfg_wr | input | 1 | Service strobe: enable or count register was written |
| status_clr | input | 1 | Clears the alarm |
| hw_code | input | CODE_W | Normal frequency-select code |
| ratio_sel | input | RATIO_W | Registered output-divider select word |
| freq_code | output | CODE_W | Active frequency-select code |
| alarm | output | 1 | Alarm status |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The vector table covers both unit sizes and counts of 0, 1, 2 and 4, and checks the tick just before expiry as well as the expiry tick itself. An off-by-one counter would alarm one unit early or late, and a design that ignores `base_sel` would be off by a factor of three. Directed cases target points where a buggy design behaves visibly wrong:
- a service write mid-count: without a reload, the design alarms early;
- disable and re-enable: a design that keeps the stale count alarms early;
- a change of `safe_code` during alarm: a design that does not latch the code lets `freq_code` move;
- `cfg_wr` or `wd_en` during alarm: a design that lets them clear the status loses the alarm;
- a ratio change while the timer is disabled: a design that gates the monitor with the enable misses the reset.

The reset width is checked on both sides of its last tick.

// File: rtl/fgw_pkg.sv
package fgw_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_ALARM = 2'd2
    } wd_state_e;

    typedef enum logic {
        RP_IDLE = 1'b0,
        RP_HOLD = 1'b1
    } rp_state_e;
endpackage

// File: rtl/fgw_prescale.sv
module fgw_prescale #(
    parameter int SLOW_DIV = 580,
    parameter int FAST_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic base_sel,
    input  logic tick,
    output logic unit
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW     = $clog2(MAXDIV + 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = base_sel ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
        unit = run && !restart && tick && (cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt >= lim) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fgw_ctrl.sv
module fgw_ctrl
    import fgw_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_en,
    input  logic              cfg_wr,
    input  logic              status_clr,
    input  logic [CNT_W-1:0]  wd_count,
    input  logic [CODE_W-1:0] safe_code,
    input  logic              unit,
    output logic              running,
    output logic              expire,
    output logic              alarm,
    output logic [CODE_W-1:0] safe_q
);
    wd_state_e        state, nxt;
    logic [CNT_W-1:0] rem;
    logic             last_unit;

    assign last_unit = (rem <= CNT_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF:   if (wd_en) nxt = WD_RUN;
            WD_RUN: begin
                if (!wd_en)                                nxt = WD_OFF;
                else if (unit && !cfg_wr && last_unit)     nxt = WD_ALARM;
            end
            WD_ALARM: if (status_clr) nxt = wd_en ? WD_RUN : WD_OFF;
            default:  nxt = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem    <= '0;
            safe_q <= '0;
        end else begin
            unique case (state)
                WD_RUN: begin
                    if (cfg_wr) begin
                        rem <= wd_count;
                    end else if (unit && !last_unit) begin
                        rem <= rem - 1'b1;
                    end
                    if (nxt == WD_ALARM) safe_q <= safe_code;
                end
                default: rem <= wd_count;
            endcase
        end
    end

    always_comb begin
        running = (state == WD_RUN);
        alarm   = (state == WD_ALARM);
        expire  = (state == WD_RUN) && (nxt == WD_ALARM);
    end
endmodule

// File: rtl/fgw_ratio_det.sv
module fgw_ratio_det #(
    parameter int RATIO_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic               changed
);
    logic [RATIO_W-1:0] ratio_q;
    logic               primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= '0;
            primed  <= 1'b0;
        end else begin
            ratio_q <= ratio_sel;
            primed  <= 1'b1;
        end
    end

    assign changed = primed && (ratio_sel != ratio_q);
endmodule

// File: rtl/fgw_rst_pulse.sv
module fgw_rst_pulse
    import fgw_pkg::*;
#(
    parameter int RST_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic tick,
    output logic sys_rst_n
);
    localparam int HW = $clog2(RST_TICKS + 1);

    rp_state_e     state, nxt;
    logic [HW-1:0] hcnt;
    logic          done;

    assign done = tick && (hcnt == HW'(RST_TICKS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            RP_IDLE: if (trigger) nxt = RP_HOLD;
            RP_HOLD: if (!trigger && done) nxt = RP_IDLE;
            default: nxt = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RP_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (trigger || state == RP_IDLE) begin
            hcnt <= '0;
        end else if (tick) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign sys_rst_n = (state == RP_IDLE);
endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt #(
    parameter int CNT_W     = 8,
    parameter int CODE_W    = 5,
    parameter int RATIO_W   = 24,
    parameter int SLOW_DIV  = 580,
    parameter int FAST_DIV  = 1,
    parameter int RST_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wd_en,
    input  logic               base_sel,
    input  logic [CNT_W-1:0]   wd_count,
    input  logic [CODE_W-1:0]  safe_code,
    input  logic               cfg_wr,
    input  logic               status_clr,
    input  logic [CODE_W-1:0]  hw_code,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic [CODE_W-1:0]  freq_code,
    output logic               alarm,
    output logic               sys_rst_n
);
    logic              running;
    logic              unit;
    logic              expire;
    logic              ratio_chg;
    logic [CODE_W-1:0] safe_q;

    fgw_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (cfg_wr),
        .base_sel (base_sel),
        .tick     (tick),
        .unit     (unit)
    );

    fgw_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_en      (wd_en),
        .cfg_wr     (cfg_wr),
        .status_clr (status_clr),
        .wd_count   (wd_count),
        .safe_code  (safe_code),
        .unit       (unit),
        .running    (running),
        .expire     (expire),
        .alarm      (alarm),
        .safe_q     (safe_q)
    );

    fgw_ratio_det #(.RATIO_W(RATIO_W)) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .changed   (ratio_chg)
    );

    fgw_rst_pulse #(.RST_TICKS(RST_TICKS)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (expire || ratio_chg),
        .tick      (tick),
        .sys_rst_n (sys_rst_n)
    );

    assign freq_code = alarm ? safe_q : hw_code;
endmodule

// File: rtl/fgw_checker.sv
module fgw_checker #(
    parameter int CODE_W  = 5,
    parameter int RATIO_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wd_en,
    input logic               status_clr,
    input logic [CODE_W-1:0]  hw_code,
    input logic [RATIO_W-1:0] ratio_sel,
    input logic [CODE_W-1:0]  freq_code,
    input logic               alarm,
    input logic               sys_rst_n
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 1'b1;
        end
    end

    p_normal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> freq_code == hw_code);

    p_safe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && $past(alarm)) |-> freq_code == $past(freq_code));

    p_no_alarm_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $rose(alarm)) |-> $past(wd_en));

    p_expiry_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $rose(alarm)) |-> !sys_rst_n);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> !alarm);

    p_ratio_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(ratio_sel) != $past(ratio_sel, 2)) |-> !sys_rst_n);
endmodule

bind freq_guard_wdt fgw_checker #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) u_chk (.*);

// File: tb/freq_guard_wdt_tb.sv
module freq_guard_wdt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_DIV   = 3;
    localparam int FAST_DIV   = 1;
    localparam int RST_TICKS  = 2;
    localparam int NVEC       = 5;

    // {base_sel, count, safe code, ticks to expiry}
    localparam logic [29:0] VEC [0:NVEC-1] = '{
        {1'b1, 8'd4, 5'h0A, 16'd4},
        {1'b0, 8'd2, 5'h13, 16'd6},
        {1'b1, 8'd1, 5'h1F, 16'd1},
        {1'b1, 8'd0, 5'h07, 16'd1},
        {1'b0, 8'd1, 5'h00, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wd_en = 1'b0;
    logic        base_sel = 1'b0;
    logic [7:0]  wd_count = 8'd15;
    logic [4:0]  safe_code = 5'h00;
    logic        cfg_wr = 1'b0;
    logic        status_clr = 1'b0;
    logic [4:0]  hw_code = 5'h11;
    logic [23:0] ratio_sel = 24'h0;
    logic [4:0]  freq_code;
    logic        alarm;
    logic        sys_rst_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_guard_wdt #(
        .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .RST_TICKS(RST_TICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .base_sel(base_sel),
        .wd_count(wd_count), .safe_code(safe_code), .cfg_wr(cfg_wr),
        .status_clr(status_clr), .hw_code(hw_code), .ratio_sel(ratio_sel),
        .freq_code(freq_code), .alarm(alarm), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse_cfg();
        @(negedge clk) cfg_wr = 1'b1;
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) status_clr = 1'b1;
        @(negedge clk) status_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 alarm", alarm, 0);
        chk("R1 rst", sys_rst_n, 1);
        chk("R1 code", freq_code, 5'h11);

        // R3 disabled never alarms
        ticks(20);
        chk("R3 disabled alarm", alarm, 0);
        chk("R3 disabled rst", sys_rst_n, 1);

        // R2 R5 R7 table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            base_sel  = VEC[v][29];
            wd_count  = VEC[v][28:21];
            safe_code = VEC[v][20:16];
            wd_en     = 1'b1;
            pulse_cfg();
            ticks(int'(VEC[v][15:0]) - 1);
            chk("R2 before expiry", alarm, 0);
            chk("R9 code before expiry", freq_code, 5'h11);
            ticks(1);
            chk("R2 at expiry", alarm, 1);
            chk("R5 safe code", freq_code, int'(VEC[v][20:16]));
            chk("R7 rst low", sys_rst_n, 0);
            ticks(RST_TICKS - 1);
            chk("R7 rst still low", sys_rst_n, 0);
            ticks(1);
            chk("R7 rst released", sys_rst_n, 1);
            @(negedge clk) wd_en = 1'b0;
            pulse_clr();
            chk("R6 cleared", alarm, 0);
            chk("R6 code back", freq_code, 5'h11);
        end

        // R4 service reload
        base_sel = 1'b1; wd_count = 8'd4; safe_code = 5'h05; wd_en = 1'b1;
        pulse_cfg();
        ticks(3);
        pulse_cfg();
        ticks(3);
        chk("R4 no alarm after service", alarm, 0);
        ticks(1);
        chk("R4 alarm after full count", alarm, 1);

        // R5 R6 sticky alarm, ignores inputs
        @(negedge clk) safe_code = 5'h1C;
        pulse_cfg();
        @(negedge clk) wd_en = 1'b0;
        ticks(6);
        chk("R6 alarm sticky", alarm, 1);
        chk("R5 code latched", freq_code, 5'h05);
        // R6 clear with enable restarts full count
        @(negedge clk) begin wd_en = 1'b1; wd_count = 8'd2; end
        pulse_clr();
        chk("R6 cleared en", alarm, 0);
        ticks(1);
        chk("R6 restart partial", alarm, 0);
        ticks(1);
        chk("R6 restart expiry", alarm, 1);
        ticks(RST_TICKS);
        @(negedge clk) wd_en = 1'b0;
        pulse_clr();

        // R3 disable mid-count, re-enable fresh
        @(negedge clk) begin wd_en = 1'b1; wd_count = 8'd2; end
        pulse_cfg();
        ticks(1);
        @(negedge clk) wd_en = 1'b0;
        ticks(5);
        chk("R3 abandoned count", alarm, 0);
        @(negedge clk) wd_en = 1'b1;
        @(negedge clk);
        ticks(1);
        chk("R3 fresh count", alarm, 0);
        ticks(1);
        chk("R3 fresh expiry", alarm, 1);
        ticks(RST_TICKS);
        @(negedge clk) wd_en = 1'b0;
        pulse_clr();

        // R8 ratio change with timer disabled
        @(negedge clk) begin ratio_sel = 24'h00A5C3; hw_code = 5'h0E; end
        @(negedge clk);
        chk("R8 rst low", sys_rst_n, 0);
        chk("R8 alarm untouched", alarm, 0);
        chk("R9 code follows hw", freq_code, 5'h0E);
        ticks(RST_TICKS - 1);
        chk("R8 rst still low", sys_rst_n, 0);
        ticks(1);
        chk("R8 rst released", sys_rst_n, 1);
        repeat (10) @(negedge clk);
        chk("R8 steady ratio no rst", sys_rst_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule